// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block forms the memory address for a load or store in a 64-bit load/store machine, and when the addressing form updates its base register it also forms the value to write back. Each request carries an addressing mode, a base value, an index value, a raw immediate field and the access size. The access size is given as log2 of the byte count: 0 means 1 byte, 1 means 2 bytes, 2 means 4 bytes and 3 means 8 bytes. For PC-relative literal loads, the caller places the program counter on the base input.

Requests enter on a valid/ready handshake. A request is accepted in any cycle where `in_valid` and `in_ready` are both high. Its result is registered and is presented with `out_valid` on the next cycle. A downstream stage applies back-pressure by holding `out_ready` low. While it does so, the result stays frozen and new requests are refused. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so a full-rate stream is possible with no bubbles.

Top module: `ls_agu`

## Requirements
- R1: Mode 0 (scaled unsigned immediate) gives address = base + (zero-extended imm[11:0] << size). Immediate bits 18:12 are ignored. With an immediate of zero this is plain register-indirect addressing, and an 8-byte access reaches at most base + 0x7ff8.
- R2: Mode 1 (unscaled signed immediate) gives address = base + sign-extended imm[8:0], with no scaling, so the offset spans -256 to 255. Immediate bits 18:9 are ignored.
- R3: Mode 2 (pre-index) gives address = base + sign-extended imm[8:0]. It drives `out_wb_en` high, and `out_wb_data` equals that same address.
- R4: Mode 3 (post-index) gives address = base, unmodified. It drives `out_wb_en` high with `out_wb_data` = base + sign-extended imm[8:0].
- R5: Mode 4 (register index) first widens the index according to `in_idx_ext`: code 1 zero-extends index[31:0], code 2 sign-extends index[31:0], and codes 0 and 3 use all 64 bits. The widened index is then shifted left by `size` when `in_idx_shift` is 1 (by 0 otherwise) and added to base.
- R6: Mode 5 (literal) gives address = base (the PC) + (sign-extended imm[18:0] << 2), a reach of about ±1 MB.
- R7: In every mode other than 2 and 3, `out_wb_en` is 0 and `out_wb_data` is 0. Modes 6 and 7 are reserved and give address = base.
- R8: `out_misaligned` is 1 exactly when the address is not a multiple of 2^size bytes.
- R9: A result appears on the cycle after acceptance. While `out_valid` is high and `out_ready` is low, the outputs hold and `in_ready` is 0. `out_valid` falls after a drain cycle that has no new input.
- R10: During reset `out_valid` is 0, all result outputs are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| in_mode | input | 3 | Addressing mode code (0..7) |
| in_size | input | 2 | log2 of access bytes |
| in_imm | input | 19 | Raw immediate field |
| in_base | input | 64 | Base register or program counter |
| in_index | input | 64 | Index register value |
| in_idx_ext | input | 2 | Index widening select |
| in_idx_shift | input | 1 | Scale index by access size |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream accepts result |
| out_addr | output | 64 | Effective access address |
| out_wb_data | output | 64 | Base writeback value |
| out_wb_en | output | 1 | Base writeback requested |
| out_misaligned | output | 1 | Address not aligned to size |

## Verification
The in-RTL properties check the following on every accepted request or stalled cycle. The post-index address equals the incoming base. Pre-index writeback matches the address. Modes without writeback leave writeback clear. Byte accesses never flag misalignment. A zero unsigned offset returns the base. The result stays frozen under back-pressure. The arithmetic of the scaled, signed, extended-index and literal offsets, including wrap-around and the ignored upper immediate bits, can be shown only by the bench's sweep over modes, sizes, immediates, bases and index widenings, which it compares against offsets it computes by multiplication.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [2:0] {
    AM_UIMM = 3'd0,
    AM_SIMM = 3'd1,
    AM_PRE  = 3'd2,
    AM_POST = 3'd3,
    AM_REG  = 3'd4,
    AM_LIT  = 3'd5,
    AM_RSV6 = 3'd6,
    AM_RSV7 = 3'd7
  } agu_mode_e;

  typedef enum logic [1:0] {
    IX_FULL  = 2'd0,
    IX_UXT32 = 2'd1,
    IX_SXT32 = 2'd2,
    IX_FULLB = 2'd3
  } agu_ext_e;
endpackage

// File: rtl/agu_offset_gen.sv
module agu_offset_gen
  import agu_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int UIMM_W = 12,
  parameter int SIMM_W = 9,
  parameter int LIT_W  = 19,
  parameter int LIT_SH = 2,
  parameter int NIDX_W = 32,
  parameter int SZ_W   = 2
) (
  input  logic [2:0]        mode,
  input  logic [SZ_W-1:0]   size,
  input  logic [LIT_W-1:0]  imm,
  input  logic [ADDR_W-1:0] index,
  input  logic [1:0]        idx_ext,
  input  logic              idx_shift,
  output logic [ADDR_W-1:0] offset,
  output logic              keep_base,
  output logic              wb_en
);
  logic [ADDR_W-1:0] uimm_off, simm_off, lit_off, idx_wide, reg_off;
  logic [SZ_W-1:0]   idx_sh;
  agu_mode_e         m;

  assign m        = agu_mode_e'(mode);
  assign uimm_off = ADDR_W'(imm[UIMM_W-1:0]) << size;
  assign simm_off = {{(ADDR_W-SIMM_W){imm[SIMM_W-1]}}, imm[SIMM_W-1:0]};
  assign lit_off  = {{(ADDR_W-LIT_W){imm[LIT_W-1]}}, imm} << LIT_SH;
  assign idx_sh   = idx_shift ? size : '0;

  always_comb begin
    case (agu_ext_e'(idx_ext))
      IX_UXT32: idx_wide = {{(ADDR_W-NIDX_W){1'b0}}, index[NIDX_W-1:0]};
      IX_SXT32: idx_wide = {{(ADDR_W-NIDX_W){index[NIDX_W-1]}}, index[NIDX_W-1:0]};
      default:  idx_wide = index;
    endcase
  end

  assign reg_off = idx_wide << idx_sh;

  always_comb begin
    offset    = '0;
    keep_base = 1'b0;
    wb_en     = 1'b0;
    case (m)
      AM_UIMM: offset = uimm_off;
      AM_SIMM: offset = simm_off;
      AM_PRE: begin
        offset = simm_off;
        wb_en  = 1'b1;
      end
      AM_POST: begin
        offset    = simm_off;
        keep_base = 1'b1;
        wb_en     = 1'b1;
      end
      AM_REG:  offset = reg_off;
      AM_LIT:  offset = lit_off;
      default: offset = '0;
    endcase
  end
endmodule

// File: rtl/agu_addr_sum.sv
module agu_addr_sum #(
  parameter int ADDR_W = 64,
  parameter int SZ_W   = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] offset,
  input  logic              keep_base,
  input  logic              wb_en,
  input  logic [SZ_W-1:0]   size,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] wb_data,
  output logic              misaligned
);
  localparam int LOW_W = (1 << SZ_W) - 1;

  logic [ADDR_W-1:0] sum;
  logic [LOW_W-1:0]  low_mask;

  assign sum      = base + offset;
  assign addr     = keep_base ? base : sum;
  assign wb_data  = wb_en ? sum : '0;
  assign low_mask = LOW_W'((1 << size) - 1);

  generate
    if (LOW_W > 0) begin : g_align
      assign misaligned = |(addr[LOW_W-1:0] & low_mask);
    end else begin : g_noalign
      assign misaligned = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/agu_out_stage.sv
module agu_out_stage #(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] d_addr,
  input  logic [ADDR_W-1:0] d_wb_data,
  input  logic              d_wb_en,
  input  logic              d_misaligned,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] q_addr,
  output logic [ADDR_W-1:0] q_wb_data,
  output logic              q_wb_en,
  output logic              q_misaligned
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      q_addr       <= '0;
      q_wb_data    <= '0;
      q_wb_en      <= 1'b0;
      q_misaligned <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (take) begin
        q_addr       <= d_addr;
        q_wb_data    <= d_wb_data;
        q_wb_en      <= d_wb_en;
        q_misaligned <= d_misaligned;
      end
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(q_addr) && $stable(q_wb_data) && $stable(q_wb_en)); // R9
  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid); // R9
endmodule

// File: rtl/ls_agu.sv
module ls_agu
  import agu_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int UIMM_W = 12,
  parameter int SIMM_W = 9,
  parameter int LIT_W  = 19,
  parameter int LIT_SH = 2,
  parameter int NIDX_W = 32,
  parameter int SZ_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_mode,
  input  logic [SZ_W-1:0]   in_size,
  input  logic [LIT_W-1:0]  in_imm,
  input  logic [ADDR_W-1:0] in_base,
  input  logic [ADDR_W-1:0] in_index,
  input  logic [1:0]        in_idx_ext,
  input  logic              in_idx_shift,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [ADDR_W-1:0] out_wb_data,
  output logic              out_wb_en,
  output logic              out_misaligned
);
  logic [ADDR_W-1:0] offset, c_addr, c_wb_data;
  logic              keep_base, c_wb_en, c_mis;

  agu_offset_gen #(
    .ADDR_W(ADDR_W), .UIMM_W(UIMM_W), .SIMM_W(SIMM_W), .LIT_W(LIT_W),
    .LIT_SH(LIT_SH), .NIDX_W(NIDX_W), .SZ_W(SZ_W)
  ) u_off (
    .mode(in_mode), .size(in_size), .imm(in_imm), .index(in_index),
    .idx_ext(in_idx_ext), .idx_shift(in_idx_shift),
    .offset(offset), .keep_base(keep_base), .wb_en(c_wb_en)
  );

  agu_addr_sum #(.ADDR_W(ADDR_W), .SZ_W(SZ_W)) u_sum (
    .base(in_base), .offset(offset), .keep_base(keep_base), .wb_en(c_wb_en),
    .size(in_size), .addr(c_addr), .wb_data(c_wb_data), .misaligned(c_mis)
  );

  agu_out_stage #(.ADDR_W(ADDR_W)) u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .d_addr(c_addr), .d_wb_data(c_wb_data), .d_wb_en(c_wb_en), .d_misaligned(c_mis),
    .out_valid(out_valid), .out_ready(out_ready),
    .q_addr(out_addr), .q_wb_data(out_wb_data), .q_wb_en(out_wb_en),
    .q_misaligned(out_misaligned)
  );

  AST_POST_KEEPS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_mode == AM_POST |=> out_addr == $past(in_base)); // R4
  AST_PRE_WB_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_mode == AM_PRE |=> out_wb_en && out_wb_data == out_addr); // R3
  AST_NO_WB_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_mode != AM_PRE && in_mode != AM_POST
    |=> !out_wb_en && out_wb_data == '0); // R7
  AST_BYTE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_size == '0 |=> !out_misaligned); // R8
  AST_INDIRECT_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_mode == AM_UIMM && in_imm[UIMM_W-1:0] == '0
    |=> out_addr == $past(in_base)); // R1
endmodule

// File: tb/ls_agu_tb.sv
module ls_agu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_mode = '0;
  logic [1:0]  in_size = '0;
  logic [18:0] in_imm = '0;
  logic [63:0] in_base = '0;
  logic [63:0] in_index = '0;
  logic [1:0]  in_idx_ext = '0;
  logic        in_idx_shift = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_addr, out_wb_data;
  logic        out_wb_en, out_misaligned;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ls_agu u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_size(in_size), .in_imm(in_imm), .in_base(in_base),
    .in_index(in_index), .in_idx_ext(in_idx_ext), .in_idx_shift(in_idx_shift),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_wb_data(out_wb_data), .out_wb_en(out_wb_en), .out_misaligned(out_misaligned)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string mode_req(input int m);
    case (m)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic model(input int m, input int s, input logic [18:0] imm,
                       input logic [63:0] base, input logic [63:0] idx,
                       input int ext, input int sh,
                       output logic [63:0] a, output logic [63:0] w,
                       output logic we, output logic mis);
    logic [63:0] off, iv, sum;
    off = '0;
    case (m)
      0: off = 64'(imm[11:0]) * (64'd1 << s);
      1, 2, 3: off = 64'($signed(imm[8:0]));
      4: begin
        if (ext == 1) iv = {32'h0, idx[31:0]};
        else if (ext == 2) iv = 64'($signed(idx[31:0]));
        else iv = idx;
        off = iv * ((sh != 0) ? (64'd1 << s) : 64'd1);
      end
      5: off = 64'($signed(imm)) * 64'd4;
      default: off = '0;
    endcase
    sum = base + off;
    a   = (m == 3) ? base : sum;
    we  = (m == 2 || m == 3);
    w   = we ? sum : '0;
    mis = (a & ((64'd1 << s) - 64'd1)) != 64'd0;
  endtask

  task automatic send_and_check(input int m, input int s, input logic [18:0] imm,
                                input logic [63:0] base, input logic [63:0] idx,
                                input int ext, input int sh);
    logic [63:0] ea, ew;
    logic ewe, emis;
    model(m, s, imm, base, idx, ext, sh, ea, ew, ewe, emis);
    @(negedge clk);
    in_mode = 3'(m); in_size = 2'(s); in_imm = imm; in_base = base;
    in_index = idx; in_idx_ext = 2'(ext); in_idx_shift = sh[0];
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, "R9", 64'(out_valid), 64'd1);
    check(out_addr == ea, mode_req(m), out_addr, ea);
    check(out_wb_en == ewe, (ewe ? mode_req(m) : "R7"), 64'(out_wb_en), 64'(ewe));
    check(out_wb_data == ew, (ewe ? mode_req(m) : "R7"), out_wb_data, ew);
    check(out_misaligned == emis, "R8", 64'(out_misaligned), 64'(emis));
  endtask

  initial begin
    logic [18:0] imms [6];
    logic [63:0] bases [3];
    logic [63:0] ea, ew;
    logic ewe, emis;
    imms[0] = 19'h00000; imms[1] = 19'h00001; imms[2] = 19'h000ff;
    imms[3] = 19'h00100; imms[4] = 19'h7ffff; imms[5] = 19'h40abc;
    bases[0] = 64'h0; bases[1] = 64'h0000_0000_1000_0003; bases[2] = 64'hffff_ffff_ffff_fff8;

    // R10: reset state
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R10", 64'(out_valid), 64'd0);
    check(in_ready == 1'b1, "R10", 64'(in_ready), 64'd1);
    check(out_addr == '0 && out_wb_data == '0, "R10", out_addr | out_wb_data, 64'd0);
    check(out_wb_en == 1'b0 && out_misaligned == 1'b0, "R10", 64'(out_wb_en | out_misaligned), 64'd0);
    rst_n = 1'b1;

    // R1: largest scaled doubleword offset
    send_and_check(0, 3, 19'h00fff, 64'h0, 64'h0, 0, 0);
    check(out_addr == 64'h7ff8, "R1", out_addr, 64'h7ff8);

    // full sweep across modes, sizes, immediates, bases, widenings
    for (int m = 0; m < 8; m++)
      for (int s = 0; s < 4; s++)
        for (int k = 0; k < 6; k++)
          for (int b = 0; b < 3; b++)
            for (int e = 0; e < 4; e++)
              for (int sh = 0; sh < 2; sh++)
                send_and_check(m, s, imms[k], bases[b],
                               (k % 2 == 1) ? 64'hfedc_ba98_8000_0005 : 64'h0000_0001_7fff_fff3,
                               e, sh);

    // R9: back-pressure hold and refusal
    @(negedge clk);
    out_ready = 1'b0;
    in_mode = 3'd1; in_size = 2'd0; in_imm = 19'h00010; in_base = 64'h100;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_imm = 19'h00020; in_base = 64'h200;
    for (int c = 0; c < 3; c++) begin
      check(in_ready == 1'b0, "R9", 64'(in_ready), 64'd0);
      check(out_valid && out_addr == 64'h110, "R9", out_addr, 64'h110);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    model(1, 0, 19'h00020, 64'h200, 64'h0, 0, 0, ea, ew, ewe, emis);
    check(out_valid && out_addr == ea, "R9", out_addr, ea);
    @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R9", 64'(out_valid), 64'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule